// File: doc/BRIEF.md
# Compressed Control-Flow Next-PC Unit

This block works out where a 16-bit-encoded control-transfer instruction sends the program counter. It takes a decoded operation code, the current 32-bit PC, the value read from the source register and an offset that an earlier stage has already sign-extended. From these it produces the next PC, a link-register write (enable, index and data), a taken flag and a halt request. Every non-control operation simply moves on by one 16-bit parcel. The block also turns the source register selection into an architectural register index, so that the register file can be read in the same cycle.

Link values and fall-through addresses are PC+2. Targets that come from a register have bit 0 cleared. The PC-relative jump and its link-free variant use a single adder and differ only in the link index. All results are registered and appear one clock after the inputs are presented. The register-read index is combinational.

Top module: `cf_nextpc`

## Requirements
- R1: While rst_n is low, every registered output reads zero. Once reset is released, each registered output shows the result for the inputs present at the previous rising clock edge.
- R2: For op code 1 (register jump), next PC = register value with bit 0 cleared, taken = 1, and no link write happens (enable 0, index 0, data 0).
- R3: For op code 2 (register jump-and-link), next PC = register value with bit 0 cleared, link enable = 1, link index = 1, link data = PC+2, taken = 1.
- R4: For op code 3 (relative jump-and-link), next PC = PC + offset, link enable = 1, link index = 1, link data = PC+2, taken = 1.
- R5: For op code 4 (relative jump), next PC = PC + offset and taken = 1. Its link target is index 0, so the link enable stays 0, while link data still reads PC+2. A link enable is never raised with index 0.
- R6: For op code 5 (branch if zero), next PC = PC + offset with taken = 1 when the register value is zero. Otherwise next PC = PC+2 with taken = 0. There is no link write.
- R7: For op code 6 (branch if non-zero), next PC = PC + offset with taken = 1 when the register value is non-zero. Otherwise next PC = PC+2 with taken = 0. There is no link write.
- R8: The read index output equals 8 + the 3-bit compressed index for op codes 5 and 6. For every other code it equals the 5-bit full index. It follows the inputs in the same cycle.
- R9: For op code 7 (breakpoint), halt = 1, next PC = current PC, taken = 0, and there is no link write.
- R10: For op code 0 and codes 8 to 15, next PC = PC+2, taken = 0, halt = 0, and there is no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| pc_i | input | 32 | Current PC |
| full_idx_i | input | 5 | Full source register index |
| cmp_idx_i | input | 3 | Compressed source register index |
| rs_idx_o | output | 5 | Architectural index to read |
| rs_val_i | input | 32 | Value of the register read |
| offset_i | input | 32 | Sign-extended offset |
| next_pc_o | output | 32 | Next PC |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Link value |
| taken_o | output | 1 | Control transfer taken |
| halt_o | output | 1 | Breakpoint halt request |

## Verification
Two functions can occur together in one cycle: the link write and the redirect. On a jump-and-link, the link data (PC+2) and the next PC (PC+offset, or the masked register value) are produced in the same cycle from the same PC. The sweep provokes this with forward, backward and zero offsets, PCs close to the 32-bit wrap, and odd register values. Each cycle's link data and next PC are judged separately against sums computed in the bench. This shows that the shared PC+2 adder does not leak into the target path, and that the target path does not leak into the link path.

// File: rtl/cf_pkg.sv
package cf_pkg;
    parameter int XLEN = 32;
    parameter int RIDX = 5;
    parameter int CIDX = 3;
    parameter int OPW  = 4;

    localparam logic [RIDX-1:0] CMP_BASE = RIDX'(8);
    localparam logic [RIDX-1:0] LINK_REG = RIDX'(1);
    localparam logic [XLEN-1:0] PARCEL   = XLEN'(2);

    typedef enum logic [OPW-1:0] {
        CF_NONE = 4'd0,
        CF_RJMP = 4'd1,
        CF_RCALL = 4'd2,
        CF_CALL = 4'd3,
        CF_JMP  = 4'd4,
        CF_BZ   = 4'd5,
        CF_BNZ  = 4'd6,
        CF_BRK  = 4'd7
    } cf_op_e;

    typedef struct packed {
        logic [XLEN-1:0] npc;
        logic            lwe;
        logic [RIDX-1:0] lidx;
        logic [XLEN-1:0] ldata;
        logic            taken;
        logic            halt;
    } cf_res_t;
endpackage

// File: rtl/cf_src_map.sv
module cf_src_map
    import cf_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [RIDX-1:0] full_idx,
    input  logic [CIDX-1:0] cmp_idx,
    output logic [RIDX-1:0] rd_idx
);
    logic use_cmp;
    always_comb begin
        use_cmp = (op == CF_BZ) || (op == CF_BNZ);
        rd_idx  = use_cmp ? (CMP_BASE + RIDX'(cmp_idx)) : full_idx;
    end
endmodule

// File: rtl/cf_target.sv
module cf_target
    import cf_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rval,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] rel_pc,
    output logic [XLEN-1:0] ind_pc
);
    always_comb begin
        seq_pc = pc + PARCEL;
        rel_pc = pc + offset;
        ind_pc = {rval[XLEN-1:1], 1'b0};
    end
endmodule

// File: rtl/cf_cond.sv
module cf_cond
    import cf_pkg::*;
(
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] rval,
    output logic            br_take
);
    logic is_zero;
    always_comb begin
        is_zero = (rval == '0);
        br_take = ((op == CF_BZ) && is_zero) || ((op == CF_BNZ) && !is_zero);
    end
endmodule

// File: rtl/cf_nextpc.sv
module cf_nextpc
    import cf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  op_i,
    input  logic [31:0] pc_i,
    input  logic [4:0]  full_idx_i,
    input  logic [2:0]  cmp_idx_i,
    output logic [4:0]  rs_idx_o,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] offset_i,
    output logic [31:0] next_pc_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_data_o,
    output logic        taken_o,
    output logic        halt_o
);
    logic [XLEN-1:0] seq_pc, rel_pc, ind_pc;
    logic            br_take;
    cf_res_t         res_d, res_q;

    cf_src_map u_map (
        .op(op_i), .full_idx(full_idx_i), .cmp_idx(cmp_idx_i), .rd_idx(rs_idx_o)
    );
    cf_target u_tgt (
        .pc(pc_i), .rval(rs_val_i), .offset(offset_i),
        .seq_pc(seq_pc), .rel_pc(rel_pc), .ind_pc(ind_pc)
    );
    cf_cond u_cond (
        .op(op_i), .rval(rs_val_i), .br_take(br_take)
    );

    always_comb begin
        res_d       = '0;
        res_d.npc   = seq_pc;
        case (op_i)
            CF_RJMP: begin
                res_d.npc   = ind_pc;
                res_d.taken = 1'b1;
            end
            CF_RCALL: begin
                res_d.npc   = ind_pc;
                res_d.lidx  = LINK_REG;
                res_d.ldata = seq_pc;
                res_d.taken = 1'b1;
            end
            CF_CALL, CF_JMP: begin
                res_d.npc   = rel_pc;
                res_d.lidx  = (op_i == CF_CALL) ? LINK_REG : '0;
                res_d.ldata = seq_pc;
                res_d.taken = 1'b1;
            end
            CF_BZ, CF_BNZ: begin
                res_d.npc   = br_take ? rel_pc : seq_pc;
                res_d.taken = br_take;
            end
            CF_BRK: begin
                res_d.npc  = pc_i;
                res_d.halt = 1'b1;
            end
            default: ;
        endcase
        res_d.lwe = (op_i == CF_RCALL || op_i == CF_CALL || op_i == CF_JMP)
                    && (res_d.lidx != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign next_pc_o   = res_q.npc;
    assign link_we_o   = res_q.lwe;
    assign link_idx_o  = res_q.lidx;
    assign link_data_o = res_q.ldata;
    assign taken_o     = res_q.taken;
    assign halt_o      = res_q.halt;

    AST_LINK_NOT_X0: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != 5'd0)); // R5
    AST_HALT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!taken_o && !link_we_o)); // R9
    AST_RJMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |=> (next_pc_o == {$past(rs_val_i[31:1]), 1'b0})); // R2
    AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |=> (link_we_o && link_data_o == $past(pc_i) + 32'd2)); // R4
    AST_BZ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 && rs_val_i != 32'd0) |=> (!taken_o && next_pc_o == $past(pc_i) + 32'd2)); // R6
    AST_BNZ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6 && rs_val_i == 32'd0) |=> (!taken_o && next_pc_o == $past(pc_i) + 32'd2)); // R7
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd8) |=> (!taken_o && !halt_o && next_pc_o == $past(pc_i) + 32'd2)); // R10
endmodule

// File: tb/cf_nextpc_tb_top.sv
module cf_nextpc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] pc_i = '0;
    logic [4:0]  full_idx_i = '0;
    logic [2:0]  cmp_idx_i = '0;
    logic [4:0]  rs_idx_o;
    logic [31:0] rs_val_i = '0;
    logic [31:0] offset_i = '0;
    logic [31:0] next_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_data_o;
    logic        taken_o;
    logic        halt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cf_nextpc dut_i (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h op=%0d pc=%h val=%h off=%h",
                     req, what, act, exp, op_i, pc_i, rs_val_i, offset_i);
        end
    endtask

    function automatic string req_of(int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        logic [31:0] pcs [3];
        logic [31:0] offs [3];
        logic [31:0] vals [4];
        pcs  = '{32'h0000_1000, 32'h7FFF_FFF0, 32'hFFFF_FFFE};
        offs = '{32'h0000_0020, 32'hFFFF_FFC0, 32'h0000_0000};
        vals = '{32'h0000_0000, 32'h0000_0001, 32'h0000_2345, 32'hFFFF_FFFF};

        op_i = 4'd3; pc_i = 32'h100; offset_i = 32'h40; rs_val_i = 32'h5;
        repeat (2) @(posedge clk);
        #5;
        // R1: held in reset, all registered outputs zero
        chk("R1", "next_pc", next_pc_o, 0);
        chk("R1", "link_we", 32'(link_we_o), 0);
        chk("R1", "link_data", link_data_o, 0);
        chk("R1", "taken", 32'(taken_o), 0);
        chk("R1", "halt", 32'(halt_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R8: read index mapping, same cycle
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                op_i = 4'(op); cmp_idx_i = 3'(c); full_idx_i = 5'(31 - c * 3);
                #1;
                chk("R8", "rs_idx", 32'(rs_idx_o),
                    (op == 5 || op == 6) ? 32'(8 + c) : 32'(31 - c * 3));
            end
        end

        // R2..R7, R9, R10 sweep; R1 one-cycle registration
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 3; p++) begin
                for (int o = 0; o < 3; o++) begin
                    for (int v = 0; v < 4; v++) begin
                        logic [31:0] e_npc, e_ld;
                        logic        e_we, e_tk, e_ht;
                        logic [4:0]  e_li;
                        string       r;
                        @(negedge clk);
                        op_i = 4'(op); pc_i = pcs[p]; offset_i = offs[o]; rs_val_i = vals[v];
                        e_npc = pcs[p] + 32'd2; e_ld = 0; e_we = 0; e_tk = 0; e_ht = 0; e_li = 0;
                        case (op)
                            1: begin e_npc = vals[v] & 32'hFFFF_FFFE; e_tk = 1; end
                            2: begin e_npc = vals[v] & 32'hFFFF_FFFE; e_tk = 1;
                                     e_we = 1; e_li = 1; e_ld = pcs[p] + 32'd2; end
                            3: begin e_npc = pcs[p] + offs[o]; e_tk = 1;
                                     e_we = 1; e_li = 1; e_ld = pcs[p] + 32'd2; end
                            4: begin e_npc = pcs[p] + offs[o]; e_tk = 1; e_ld = pcs[p] + 32'd2; end
                            5: if (vals[v] == 0) begin e_npc = pcs[p] + offs[o]; e_tk = 1; end
                            6: if (vals[v] != 0) begin e_npc = pcs[p] + offs[o]; e_tk = 1; end
                            7: begin e_npc = pcs[p]; e_ht = 1; end
                            default: ;
                        endcase
                        r = req_of(op);
                        @(posedge clk); #5;
                        chk(r, "next_pc", next_pc_o, e_npc);
                        chk(r, "link_we", 32'(link_we_o), 32'(e_we));
                        chk(r, "link_idx", 32'(link_idx_o), 32'(e_li));
                        chk(r, "link_data", link_data_o, e_ld);
                        chk(r, "taken", 32'(taken_o), 32'(e_tk));
                        chk(r, "halt", 32'(halt_o), 32'(e_ht));
                    end
                end
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule